// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block is a buffer with first-word-fall-through (FWFT) behaviour. It is built from a number of identical FIFO stages placed in series with no logic between them. Each stage has a write side with an active-low write enable and an active-low input-ready flag. Each stage also has a read side with an active-low read enable and an active-low output-ready flag. Inside the chain, the output-ready flag of a stage acts as the write enable of the next stage, and the input-ready flag of a stage acts as the read enable of the stage before it. A word therefore moves toward the tail without any read request, and a freed location moves back toward the head. The total capacity is the number of stages times the stage depth.

All stages share one clock, which acts as the write, read and transfer clock. The flag paths in every stage have fixed pipeline delays:

- The output-ready flag goes low exactly three clocks after a write into an empty stage.
- The input-ready flag goes low exactly two clocks after a read from a full stage.

With these delays, the chain's ripple-down time and bubble-up time follow fixed formulas in the stage count. A synchronous master reset empties every stage.

Top module: `fwft_chain`

## Requirements
- R1: While `mrst` is high at a clock edge, every stage is emptied. After that edge `outRdyN` reads 1, `inRdyN` reads 0 and `rdData` reads zero.
- R2: Whenever `outRdyN` is 0, `rdData` shows the oldest word that has not yet been read. No read request is needed to present it.
- R3: Words leave the chain in the order they were accepted, with none lost, duplicated or invented, under any mix of write and read enables.
- R4: With no reads, the chain accepts exactly STAGES*DEPTH words. `inRdyN` is never 0 while the chain holds that many words.
- R5: A write attempted while `inRdyN` is 1 is ignored. The word is never delivered.
- R6: A read attempted while `outRdyN` is 1 is ignored. It consumes nothing and does not disturb later words.
- R7: After one word is written into an empty chain, `outRdyN` goes low exactly 4*(STAGES-1)+3 clocks after the write edge.
- R8: After one read from a full chain, `inRdyN` goes low exactly 3*(STAGES-1)+2 clocks after the read edge.
- R9: While `outRdyN` is 0 and `rdEnN` is 1, the next clock leaves `outRdyN` at 0 and `rdData` unchanged.
- R10: Once the chain is full, writing and reading on every clock keeps `outRdyN` at 0 on every cycle, so the chain sustains one word per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for write, read and inter-stage transfer |
| mrst | input | 1 | Synchronous master reset, active high |
| wrData | input | WIDTH | Word offered to the head stage |
| wrEnN | input | 1 | Active-low write enable of the head stage |
| inRdyN | output | 1 | Active-low input-ready flag of the head stage (0 = a word can be accepted) |
| rdData | output | WIDTH | Word presented by the tail stage |
| rdEnN | input | 1 | Active-low read enable of the tail stage |
| outRdyN | output | 1 | Active-low output-ready flag of the tail stage (0 = `rdData` is valid) |

## Verification
If a stage's occupancy count were wrong, the fault would show at the ports in one of three ways:

- the tail offering a word the queue model does not hold;
- the tail dropping a word;
- the head accepting a write beyond STAGES*DEPTH.

A stale or miscounted pointer would show as out-of-order data at the tail within a few words. A fault in a flag pipeline changes the measured ripple-down or bubble-up latency by a whole number of clocks, so each latency is checked against its exact formula rather than a bound. A stall in the transfer handshake would break the one-word-per-clock streaming check within a few cycles of the stall.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

  // Clocks from a write edge until the word is counted as loadable on the read side.
  localparam int WR_VIS_DELAY = 2;
  // Clocks from a read edge until the freed slot is visible to the write side.
  localparam int FREE_DELAY   = 2;

  // Strobes from a stage controller to its datapath.
  typedef struct packed {
    logic memWrite;
    logic outLoad;
    logic outClear;
  } stageStrobes_t;

endpackage

// File: rtl/fwft_stage_ctrl.sv
module fwft_stage_ctrl
  import fwft_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          wrEnN,
  input  logic          rdEnN,
  output logic          inRdyN,
  output logic          outRdyN,
  output stageStrobes_t strobes,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);

  logic [CW-1:0]           heldCount;
  logic [CW-1:0]           heldNext;
  logic [CW-1:0]           visCount;
  logic [WR_VIS_DELAY-1:0] wrPipe;
  logic [FREE_DELAY-1:0]   freePipe;
  logic                    doWrite;
  logic                    doRead;
  logic                    doLoad;

  always_comb begin
    doWrite  = !wrEnN && !inRdyN;
    doRead   = !rdEnN && !outRdyN;
    doLoad   = (outRdyN || doRead) && (visCount != '0);
    heldNext = heldCount + CW'(doWrite) - CW'(freePipe[FREE_DELAY-1]);
    strobes.memWrite = doWrite && !mrst;
    strobes.outLoad  = doLoad && !mrst;
    strobes.outClear = mrst;
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      wrPipe    <= '0;
      freePipe  <= '0;
      visCount  <= '0;
      heldCount <= '0;
      wrAddr    <= '0;
      rdAddr    <= '0;
      inRdyN    <= 1'b0;
      outRdyN   <= 1'b1;
    end else begin
      wrPipe    <= {wrPipe[WR_VIS_DELAY-2:0], doWrite};
      freePipe  <= {freePipe[FREE_DELAY-2:0], doRead};
      visCount  <= visCount + CW'(wrPipe[WR_VIS_DELAY-1]) - CW'(doLoad);
      heldCount <= heldNext;
      inRdyN    <= (heldNext == CW'(DEPTH));
      outRdyN   <= !(doLoad || (!outRdyN && !doRead));
      if (doWrite) wrAddr <= wrAddr + AW'(1);
      if (doLoad)  rdAddr <= rdAddr + AW'(1);
    end
  end

endmodule

// File: rtl/fwft_stage_dp.sv
module fwft_stage_dp
  import fwft_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  stageStrobes_t    strobes,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.memWrite) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge clk) begin
    if (strobes.outClear)     dOut <= '0;
    else if (strobes.outLoad) dOut <= mem[rdAddr];
  end

endmodule

// File: rtl/fwft_stage.sv
module fwft_stage
  import fwft_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic [WIDTH-1:0] dIn,
  input  logic             wrEnN,
  output logic             inRdyN,
  output logic [WIDTH-1:0] dOut,
  input  logic             rdEnN,
  output logic             outRdyN
);

  localparam int AW = $clog2(DEPTH);

  stageStrobes_t strobes;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  fwft_stage_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .mrst(mrst), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .inRdyN(inRdyN), .outRdyN(outRdyN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  fwft_stage_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dp (
    .clk(clk), .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dIn(dIn), .dOut(dOut)
  );

endmodule

// File: rtl/fwft_chain.sv
module fwft_chain #(
  parameter int STAGES = 3,
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 9
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrEnN,
  output logic             inRdyN,
  output logic [WIDTH-1:0] rdData,
  input  logic             rdEnN,
  output logic             outRdyN
);

  logic [STAGES-1:0]            stOrN;
  logic [STAGES-1:0]            stIrN;
  logic [STAGES-1:0][WIDTH-1:0] stData;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [WIDTH-1:0] din;
    logic             wen;
    logic             ren;

    if (k == 0) begin : g_head
      assign din = wrData;
      assign wen = wrEnN;
    end else begin : g_link_in
      assign din = stData[k-1];
      assign wen = stOrN[k-1];
    end

    if (k == STAGES - 1) begin : g_tail
      assign ren = rdEnN;
    end else begin : g_link_out
      assign ren = stIrN[k+1];
    end

    fwft_stage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) stage (
      .clk(clk), .mrst(mrst), .dIn(din), .wrEnN(wen), .inRdyN(stIrN[k]),
      .dOut(stData[k]), .rdEnN(ren), .outRdyN(stOrN[k])
    );
  end

  assign inRdyN  = stIrN[0];
  assign rdData  = stData[STAGES-1];
  assign outRdyN = stOrN[STAGES-1];

endmodule

// File: rtl/fwft_chain_chk.sv
module fwft_chain_chk #(
  parameter int STAGES = 3,
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 9
) (
  input logic             clk,
  input logic             mrst,
  input logic [WIDTH-1:0] wrData,
  input logic             wrEnN,
  input logic             inRdyN,
  input logic [WIDTH-1:0] rdData,
  input logic             rdEnN,
  input logic             outRdyN
);

  localparam int TOTAL = STAGES * DEPTH;
  localparam int OW    = $clog2(TOTAL + 1) + 1;

  logic [OW-1:0] occ;
  logic          wrTaken;
  logic          rdTaken;

  assign wrTaken = !wrEnN && !inRdyN;
  assign rdTaken = !rdEnN && !outRdyN;

  always_ff @(posedge clk) begin
    if (mrst) occ <= '0;
    else      occ <= occ + OW'(wrTaken) - OW'(rdTaken);
  end

  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (mrst)
    $fell(mrst) |-> (outRdyN && !inRdyN && rdData == '0));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (mrst)
    !inRdyN |-> (occ < OW'(TOTAL)));

  assert_bounded_fill_R4: assert property (@(posedge clk) disable iff (mrst)
    occ <= OW'(TOTAL));

  assert_no_phantom_R3: assert property (@(posedge clk) disable iff (mrst)
    (occ == '0) |-> outRdyN);

  assert_hold_output_R9: assert property (@(posedge clk) disable iff (mrst)
    (!outRdyN && rdEnN) |=> (!outRdyN && $stable(rdData)));

  logic unusedWr;
  assign unusedWr = ^wrData;

endmodule

bind fwft_chain fwft_chain_chk #(.STAGES(STAGES), .DEPTH(DEPTH), .WIDTH(WIDTH)) chk (
  .clk(clk), .mrst(mrst), .wrData(wrData), .wrEnN(wrEnN), .inRdyN(inRdyN),
  .rdData(rdData), .rdEnN(rdEnN), .outRdyN(outRdyN)
);

// File: tb/fwft_chain_test.sv
module fwft_chain_test;

  localparam int STAGES = 3;
  localparam int DEPTH  = 8;
  localparam int WIDTH  = 9;
  localparam int TOTAL  = STAGES * DEPTH;
  localparam int CLK_PERIOD = 10;
  localparam int RIPPLE_LAT = 4 * (STAGES - 1) + 3;
  localparam int BUBBLE_LAT = 3 * (STAGES - 1) + 2;

  // Vector fields: [31] pseudo-random enables, [23:16] write pattern,
  // [15:8] read pattern, [7:0] cycle count. A pattern bit of 1 asserts the enable.
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'hFF, 8'h00, 8'd10},
    {8'h00, 8'hAA, 8'h55, 8'd40},
    {8'h00, 8'hFF, 8'hFF, 8'd40},
    {8'h80, 8'h00, 8'h00, 8'd150},
    {8'h00, 8'h11, 8'hEF, 8'd60},
    {8'h80, 8'h00, 8'h00, 8'd150}
  };

  logic             clk = 1'b0;
  logic             mrst;
  logic [WIDTH-1:0] wrData;
  logic             wrEnN;
  logic             inRdyN;
  logic [WIDTH-1:0] rdData;
  logic             rdEnN;
  logic             outRdyN;

  int errors = 0;
  int checks = 0;
  logic [WIDTH-1:0] model [$];
  logic [WIDTH-1:0] nextVal = '0;
  logic [15:0]      lfsr = 16'hACE1;
  bit               lastWAcc;

  fwft_chain #(.STAGES(STAGES), .DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .mrst(mrst), .wrData(wrData), .wrEnN(wrEnN), .inRdyN(inRdyN),
    .rdData(rdData), .rdEnN(rdEnN), .outRdyN(outRdyN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Called just after a falling edge: check the ports against the model,
  // drive this cycle's enables, advance to the next falling edge and update the model.
  task automatic cycle(input bit w, input bit r);
    bit wAcc;
    bit rAcc;
    if (!outRdyN) begin
      check(model.size() > 0, "R3", "tail ready with empty model", model.size(), 1);
      if (model.size() > 0)
        check(rdData == model[0], "R2", "head word", int'(rdData), int'(model[0]));
    end
    if (!inRdyN)
      check(model.size() < TOTAL, "R4", "ready while full", model.size(), TOTAL - 1);
    wrEnN  = !w;
    rdEnN  = !r;
    wrData = nextVal;
    wAcc = w && !inRdyN;
    rAcc = r && !outRdyN;
    @(negedge clk);
    if (rAcc) void'(model.pop_front());
    if (wAcc) begin
      model.push_back(nextVal);
      nextVal = nextVal + 1'b1;
    end
    lastWAcc = wAcc;
  endtask

  task automatic doReset();
    @(negedge clk);
    mrst = 1'b1; wrEnN = 1'b1; rdEnN = 1'b1;
    repeat (2) @(negedge clk);
    mrst = 1'b0;
    model.delete();
    check(outRdyN == 1'b1, "R1", "outRdyN after reset", int'(outRdyN), 1);
    check(inRdyN == 1'b0, "R1", "inRdyN after reset", int'(inRdyN), 0);
    check(rdData == '0, "R1", "rdData after reset", int'(rdData), 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && model.size() > 0; i++) cycle(1'b0, 1'b1);
    repeat (RIPPLE_LAT + 4) cycle(1'b0, 1'b0);
    check(outRdyN == 1'b1 && model.size() == 0, "R3", "chain empty after drain",
          int'(outRdyN), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int lat;
    int acc;
    mrst = 1'b1; wrEnN = 1'b1; rdEnN = 1'b1; wrData = '0;
    doReset();

    // R6: reads on an empty chain consume nothing
    repeat (5) cycle(1'b0, 1'b1);
    check(outRdyN == 1'b1, "R6", "empty after ignored reads", int'(outRdyN), 1);

    // R7: ripple-down latency of the first word
    cycle(1'b1, 1'b0);
    lat = 0;
    while (outRdyN && lat < 100) begin
      cycle(1'b0, 1'b0);
      lat++;
    end
    check(lat == RIPPLE_LAT, "R7", "ripple latency", lat, RIPPLE_LAT);
    check(rdData == model[0], "R2", "first word falls through", int'(rdData), int'(model[0]));
    cycle(1'b0, 1'b1);

    // Vector table walk: R2 and R3 under patterned and pseudo-random enables
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VEC[v][7:0]); i++) begin
        bit w;
        bit r;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (VEC[v][31]) begin
          w = lfsr[0];
          r = lfsr[5];
        end else begin
          w = VEC[v][16 + (i % 8)];
          r = VEC[v][8 + (i % 8)];
        end
        cycle(w, r);
      end
    end
    drain();

    // R4: capacity with no reads
    acc = 0;
    for (int i = 0; i < 120; i++) begin
      cycle(1'b1, 1'b0);
      if (lastWAcc) acc++;
    end
    check(acc == TOTAL, "R4", "words accepted", acc, TOTAL);
    check(inRdyN == 1'b1, "R4", "inRdyN when full", int'(inRdyN), 1);

    // R5: writes while full are dropped
    repeat (5) cycle(1'b1, 1'b0);
    check(model.size() == TOTAL && inRdyN == 1'b1, "R5", "full after ignored writes",
          model.size(), TOTAL);

    // R8: bubble-up latency after one tail read
    cycle(1'b0, 1'b1);
    lat = 0;
    while (inRdyN && lat < 100) begin
      cycle(1'b0, 1'b0);
      lat++;
    end
    check(lat == BUBBLE_LAT, "R8", "bubble latency", lat, BUBBLE_LAT);

    // R10: refill, then stream at one word per clock
    repeat (30) cycle(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) begin
      check(outRdyN == 1'b0, "R10", "tail ready while streaming", int'(outRdyN), 0);
      cycle(1'b1, 1'b1);
    end
    drain();

    // R9: holding with data present
    repeat (3) cycle(1'b1, 1'b0);
    repeat (RIPPLE_LAT + 2) cycle(1'b0, 1'b0);
    check(outRdyN == 1'b0 && rdData == model[0], "R9", "word held without read",
          int'(rdData), int'(model[0]));

    // R1: reset with data in flight
    cycle(1'b1, 1'b0);
    doReset();
    repeat (RIPPLE_LAT + 4) cycle(1'b0, 1'b0);
    check(outRdyN == 1'b1, "R1", "nothing emerges after reset", int'(outRdyN), 1);

    finishRun();
  end

endmodule